// File: doc/BRIEF.md
# Two-Level Multicore Interrupt Controller

This block collects level-sensitive interrupt source lines and delivers them to up to four processor cores. Each core gets one IRQ line and one FIQ line. A source reaches a core only if it passes two gates. The first is a global enable bit that each source has. The second is a mask bit that each source has for each core.

The identifiers from 0 to a fixed boundary (28 by default) are per-core sources. They are delivered to every core that has them unmasked, and they ignore routing. Higher identifiers are shared sources. Each shared source has a source-control word that selects which cores take it as an IRQ and which take it as an FIQ.

Software reaches the block through a simple register bus with two windows, a global one and a per-core one. An access to the per-core window acts on the registers of the core named on the bus. Enable bits and mask bits are never written as bitmaps. Software writes a source number to a set register or to a clear register. Each core reads an acknowledge register to learn the lowest-numbered source that is currently deliverable to it.

Top module: `mc_intc`

## Requirements
- R1: After reset, all global enables are clear, every mask bit of every core is set and every routing field is zero. So all IRQ and FIQ outputs are low and every core's acknowledge register reads 1023.
- R2: A global-window read at offset 0x000 returns the number of implemented sources in bits [11:2], with zeros elsewhere.
- R3: A global-window write of a source number (bits [9:0] of the write data) to offset 0x030 sets that source's enable, and a write to offset 0x034 clears it. Numbers at or above the source count change nothing and do not alias onto another source.
- R4: A per-core-window write of a source number to offset 0x048 sets that source's mask bit for the accessing core, and a write to offset 0x04C clears it. The mask bits of the other cores are unchanged.
- R5: The source-control word of source n sits in the global window at offset 0x100 + 4·n. Bit c of [3:0] routes the source to core c as IRQ, and bit 8+c routes it to core c as FIQ. Only the bits for implemented cores are stored, and a read returns them with all other bits zero.
- R6: A core's IRQ output goes high one clock after some source meets all of these: its line is high, it is enabled, it is unmasked for that core, and it is either a per-core source or IRQ-routed to that core.
- R7: A core's FIQ output goes high one clock after some shared source meets all of these: its line is high, it is enabled, it is unmasked for that core, and it is FIQ-routed to that core. Per-core sources never drive FIQ.
- R8: A per-core-window read at offset 0x044 returns in bits [9:0] the lowest source number that is IRQ- or FIQ-deliverable to the accessing core, or 1023 if there is none. The read changes no state, so repeating it returns the same value.
- R9: Sources are level sensitive. A source stops being pending as soon as its line falls or its enable is cleared, with no separate clearing action.
- R10: Per-core sources ignore their routing fields. A shared source whose routing field is zero is never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLines | input | NUM_SRC | Level-sensitive source lines, bit n is source n |
| winSel | input | 1 | 0 selects the global window, 1 selects the per-core window |
| busCpu | input | CPU_W | Number of the core making the access |
| busAddr | input | 12 | Byte offset within the selected window |
| busWrite | input | 1 | Write strobe, takes effect at the clock edge |
| busRead | input | 1 | Read strobe, the data is returned in the same cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero when no register is read |
| irqOut | output | NUM_CPUS | IRQ request, one bit per core |
| fiqOut | output | NUM_CPUS | FIQ request, one bit per core |

## Verification
The hardest case to reach is a source that has passed the global gate but is still held back on one core while it is delivered on another. Three controls have to line up at the same time for this: the line, the enable, and a per-core mask that differs between cores. The bench sweeps every source number through a fixed staircase. The staircase first raises the line and the enable with both cores masked. It then unmasks core 0 alone, then both cores, then zeroes the routing, and finally withdraws the enable. Each step is compared with an arithmetic model on both cores. After that, a set of multi-source patterns, in which the two cores have different mask sets, exercises the lowest-number selection of the acknowledge register.

// File: rtl/mc_intc_pkg.sv
package mc_intc_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int ID_W   = 10;
  localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

  localparam logic [ADDR_W-1:0] OFF_CTRL     = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_SETEN    = 12'h030;
  localparam logic [ADDR_W-1:0] OFF_CLREN    = 12'h034;
  localparam logic [ADDR_W-1:0] OFF_ACK      = 12'h044;
  localparam logic [ADDR_W-1:0] OFF_SETMSK   = 12'h048;
  localparam logic [ADDR_W-1:0] OFF_CLRMSK   = 12'h04C;
  localparam logic [ADDR_W-1:0] OFF_SRC_BASE = 12'h100;

  typedef struct packed {
    logic              setEn;
    logic              clrEn;
    logic              setMask;
    logic              clrMask;
    logic              wrRoute;
    logic              rdCtrl;
    logic              rdAck;
    logic              rdRoute;
    logic [ID_W-1:0]   idx;
    logic [DATA_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/mc_intc_ctrl.sv
module mc_intc_ctrl
  import mc_intc_pkg::*;
#(
  parameter int NUM_CPUS = 2,
  parameter int NUM_SRC  = 40,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic              winSel,
  input  logic [CPU_W-1:0]  busCpu,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           stb
);
  logic [ADDR_W-1:0] rel;
  logic              routeHit;
  logic              idOk;
  logic              cpuOk;

  always_comb begin
    rel      = busAddr - OFF_SRC_BASE;
    routeHit = (busAddr >= OFF_SRC_BASE) && (rel[1:0] == 2'b00) &&
               (32'(rel[ADDR_W-1:2]) < NUM_SRC);
    idOk     = 32'(busWdata[ID_W-1:0]) < NUM_SRC;
    cpuOk    = 32'(busCpu) < NUM_CPUS;

    stb      = '0;
    stb.data = busWdata;
    stb.idx  = busWdata[ID_W-1:0];
    if (!winSel) begin
      if (busWrite) begin
        stb.setEn = (busAddr == OFF_SETEN) && idOk;
        stb.clrEn = (busAddr == OFF_CLREN) && idOk;
        if (routeHit) begin
          stb.wrRoute = 1'b1;
          stb.idx     = rel[ADDR_W-1:2];
        end
      end
      if (busRead) begin
        stb.rdCtrl = (busAddr == OFF_CTRL);
        if (routeHit) begin
          stb.rdRoute = 1'b1;
          stb.idx     = rel[ADDR_W-1:2];
        end
      end
    end else if (cpuOk) begin
      if (busWrite) begin
        stb.setMask = (busAddr == OFF_SETMSK) && idOk;
        stb.clrMask = (busAddr == OFF_CLRMSK) && idOk;
      end
      if (busRead) stb.rdAck = (busAddr == OFF_ACK);
    end
  end
endmodule

// File: rtl/mc_intc_dp.sv
module mc_intc_dp
  import mc_intc_pkg::*;
#(
  parameter int NUM_CPUS    = 2,
  parameter int NUM_SRC     = 40,
  parameter int LAST_PERCPU = 28,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [CPU_W-1:0]   busCpu,
  input  logic [NUM_SRC-1:0] srcLines,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_CPUS-1:0] irqOut,
  output logic [NUM_CPUS-1:0] fiqOut
);
  function automatic logic [NUM_SRC-1:0] mkPercpu();
    logic [NUM_SRC-1:0] v;
    for (int s = 0; s < NUM_SRC; s++) v[s] = (s <= LAST_PERCPU);
    return v;
  endfunction

  function automatic logic [ID_W-1:0] lowestId(input logic [NUM_SRC-1:0] v);
    logic [ID_W-1:0] r;
    r = ID_NONE;
    for (int s = NUM_SRC - 1; s >= 0; s--) if (v[s]) r = ID_W'(s);
    return r;
  endfunction

  localparam logic [NUM_SRC-1:0] PERCPU_VEC = mkPercpu();

  logic [NUM_SRC-1:0]  enable;
  logic [NUM_SRC-1:0]  maskBits [NUM_CPUS];
  logic [NUM_CPUS-1:0] irqRt    [NUM_SRC];
  logic [NUM_CPUS-1:0] fiqRt    [NUM_SRC];
  logic [NUM_SRC-1:0]  irqElig  [NUM_CPUS];
  logic [NUM_SRC-1:0]  fiqElig  [NUM_CPUS];
  logic [ID_W-1:0]     ackId    [NUM_CPUS];
  logic [NUM_CPUS-1:0] irqAny;
  logic [NUM_CPUS-1:0] fiqAny;
  logic [IDX_W-1:0]    idx;

  assign idx = stb.idx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable <= '0;
      for (int c = 0; c < NUM_CPUS; c++) maskBits[c] <= '1;
      for (int s = 0; s < NUM_SRC; s++) begin
        irqRt[s] <= '0;
        fiqRt[s] <= '0;
      end
      irqOut <= '0;
      fiqOut <= '0;
    end else begin
      if (stb.setEn)   enable[idx] <= 1'b1;
      if (stb.clrEn)   enable[idx] <= 1'b0;
      if (stb.setMask) maskBits[busCpu][idx] <= 1'b1;
      if (stb.clrMask) maskBits[busCpu][idx] <= 1'b0;
      if (stb.wrRoute) begin
        irqRt[idx] <= stb.data[NUM_CPUS-1:0];
        fiqRt[idx] <= stb.data[8 +: NUM_CPUS];
      end
      irqOut <= irqAny;
      fiqOut <= fiqAny;
    end
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    always_comb begin
      for (int s = 0; s < NUM_SRC; s++) begin
        irqElig[c][s] = srcLines[s] & enable[s] & ~maskBits[c][s] &
                        (PERCPU_VEC[s] | irqRt[s][c]);
        fiqElig[c][s] = srcLines[s] & enable[s] & ~maskBits[c][s] &
                        ~PERCPU_VEC[s] & fiqRt[s][c];
      end
      irqAny[c] = |irqElig[c];
      fiqAny[c] = |fiqElig[c];
      ackId[c]  = lowestId(irqElig[c] | fiqElig[c]);
    end

    // R6: a raised IRQ needs a line that was live, enabled and unmasked
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[c] |-> $past(|(srcLines & enable & ~maskBits[c])));
    // R7: FIQ only from shared sources
    a_r7_fiq_shared: assert property (@(posedge clk) disable iff (!rstN)
      fiqOut[c] |-> $past(|(srcLines & enable & ~PERCPU_VEC)));
    // R8: a reported ID is an enabled source with its line high
    a_r8_ack_live: assert property (@(posedge clk) disable iff (!rstN)
      (ackId[c] != ID_NONE) |-> (srcLines[ackId[c][IDX_W-1:0]] &&
                                 enable[ackId[c][IDX_W-1:0]]));
  end

  always_comb begin
    rdData = '0;
    if (stb.rdCtrl) rdData[ID_W+1:2] = ID_W'(NUM_SRC);
    if (stb.rdAck)  rdData[ID_W-1:0] = ackId[busCpu];
    if (stb.rdRoute) begin
      rdData[NUM_CPUS-1:0]  = irqRt[idx];
      rdData[8 +: NUM_CPUS] = fiqRt[idx];
    end
  end

  // R3: set and clear of the global enable by number
  a_r3_set_enable: assert property (@(posedge clk) disable iff (!rstN)
    stb.setEn |=> enable[$past(idx)]);
  a_r3_clr_enable: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrEn |=> !enable[$past(idx)]);
  // R4: set and clear of the accessing core's mask bit
  a_r4_set_mask: assert property (@(posedge clk) disable iff (!rstN)
    stb.setMask |=> maskBits[$past(busCpu)][$past(idx)]);
  a_r4_clr_mask: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrMask |=> !maskBits[$past(busCpu)][$past(idx)]);
endmodule

// File: rtl/mc_intc.sv
module mc_intc
  import mc_intc_pkg::*;
#(
  parameter int NUM_CPUS    = 2,
  parameter int NUM_SRC     = 40,
  parameter int LAST_PERCPU = 28,
  localparam int CPU_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcLines,
  input  logic                winSel,
  input  logic [CPU_W-1:0]    busCpu,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrite,
  input  logic                busRead,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic [NUM_CPUS-1:0] irqOut,
  output logic [NUM_CPUS-1:0] fiqOut
);
  strobe_t stb;

  mc_intc_ctrl #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC)) u_ctrl (
    .winSel(winSel), .busCpu(busCpu), .busAddr(busAddr),
    .busWrite(busWrite), .busRead(busRead), .busWdata(busWdata), .stb(stb)
  );

  mc_intc_dp #(.NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC),
               .LAST_PERCPU(LAST_PERCPU)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busCpu(busCpu),
    .srcLines(srcLines), .rdData(busRdata), .irqOut(irqOut), .fiqOut(fiqOut)
  );
endmodule

// File: tb/tb_mc_intc.sv
module tb_mc_intc;
  localparam int NC = 2;
  localparam int NS = 40;
  localparam int LP = 28;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NS-1:0] srcLines;
  logic          winSel;
  logic [0:0]    busCpu;
  logic [11:0]   busAddr;
  logic          busWrite, busRead;
  logic [31:0]   busWdata, busRdata;
  logic [NC-1:0] irqOut, fiqOut;

  always #10 clk = ~clk;

  mc_intc #(.NUM_CPUS(NC), .NUM_SRC(NS), .LAST_PERCPU(LP)) dut (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .winSel(winSel),
    .busCpu(busCpu), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  bit enM [NS];
  bit mskM[NC][NS];
  bit irM [NS][NC];
  bit fqM [NS][NC];

  function automatic bit eligI(int c, int s);
    return srcLines[s] && enM[s] && !mskM[c][s] && (s <= LP || irM[s][c]);
  endfunction
  function automatic bit eligF(int c, int s);
    return srcLines[s] && enM[s] && !mskM[c][s] && s > LP && fqM[s][c];
  endfunction
  function automatic int expIrq(int c);
    for (int s = 0; s < NS; s++) if (eligI(c, s)) return 1;
    return 0;
  endfunction
  function automatic int expFiq(int c);
    for (int s = 0; s < NS; s++) if (eligF(c, s)) return 1;
    return 0;
  endfunction
  function automatic int expAck(int c);
    for (int s = 0; s < NS; s++) if (eligI(c, s) || eligF(c, s)) return s;
    return 1023;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic busWr(bit win, int cpu, int addr, int data);
    @(negedge clk);
    winSel = win; busCpu = 1'(cpu); busAddr = 12'(addr);
    busWdata = 32'(data); busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(bit win, int cpu, int addr, output int data);
    @(negedge clk);
    winSel = win; busCpu = 1'(cpu); busAddr = 12'(addr); busRead = 1'b1;
    #2;
    data = int'(busRdata);
    busRead = 1'b0;
  endtask

  task automatic setEn(int id);
    busWr(0, 0, 'h030, id);
    if (id < NS) enM[id] = 1;
  endtask
  task automatic clrEn(int id);
    busWr(0, 0, 'h034, id);
    if (id < NS) enM[id] = 0;
  endtask
  task automatic setMsk(int c, int id);
    busWr(1, c, 'h048, id);
    mskM[c][id] = 1;
  endtask
  task automatic clrMsk(int c, int id);
    busWr(1, c, 'h04C, id);
    mskM[c][id] = 0;
  endtask
  task automatic setRoute(int id, int ib, int fb);
    busWr(0, 0, 'h100 + 4 * id, (fb << 8) | ib | 32'hF0F0_F000);
    for (int c = 0; c < NC; c++) begin
      irM[id][c] = ib[c];
      fqM[id][c] = fb[c];
    end
  endtask

  task automatic checkAll(string req);
    int a, b;
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk(req, $sformatf("irq cpu%0d", c), int'(irqOut[c]), expIrq(c));
      chk(req, $sformatf("fiq cpu%0d", c), int'(fiqOut[c]), expFiq(c));
      busRd(1, c, 'h044, a);
      chk(req, $sformatf("ack cpu%0d", c), a & 'h3FF, expAck(c));
      chk(req, "ack upper bits", a >> 10, 0);
    end
    busRd(1, 0, 'h044, b);
    chk("R8", "repeat ack", b & 'h3FF, expAck(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    rstN = 0; srcLines = '0; winSel = 0; busCpu = 0; busAddr = '0;
    busWrite = 0; busRead = 0; busWdata = '0;
    for (int s = 0; s < NS; s++) begin
      enM[s] = 0;
      for (int c = 0; c < NC; c++) begin
        mskM[c][s] = 1; irM[s][c] = 0; fqM[s][c] = 0;
      end
    end
    repeat (4) @(negedge clk);
    rstN = 1;

    // R1: reset state, with all lines raised to prove nothing passes
    srcLines = '1;
    checkAll("R1");
    busRd(0, 0, 'h100 + 4 * 35, v);
    chk("R1", "route reset", v, 0);
    srcLines = '0;

    // R2: source count
    busRd(0, 0, 'h000, v);
    chk("R2", "ctrl reg", v, NS << 2);

    // R5: routing write and read back for every source
    for (int s = 0; s < NS; s++) begin
      setRoute(s, s % 4, (s / 4) % 4);
      busRd(0, 0, 'h100 + 4 * s, v);
      chk("R5", $sformatf("route %0d", s), v, ((((s / 4) % 4) << 8) | (s % 4)));
    end

    // R3 R4 R6 R7 R10 staircase per source
    for (int s = 0; s < NS; s++) begin
      srcLines = '0;
      srcLines[s] = 1'b1;
      setEn(s);
      setRoute(s, 1 << (s % 2), 1 << ((s + 1) % 2));
      checkAll("R3");
      clrMsk(0, s);
      checkAll("R4");
      clrMsk(1, s);
      checkAll("R6");
      checkAll("R7");
      setRoute(s, 0, 0);
      checkAll("R10");
      clrEn(s);
      checkAll("R3");
      setMsk(0, s);
      setMsk(1, s);
    end
    srcLines = '0;

    // R3: an out-of-range number must not alias onto source 5
    srcLines[5] = 1'b1;
    clrMsk(0, 5);
    clrMsk(1, 5);
    busWr(0, 0, 'h030, 64 + 5);
    checkAll("R3");
    setMsk(0, 5);
    setMsk(1, 5);
    srcLines = '0;

    // R8: multi-source patterns, different masks per core
    for (int s = 0; s < NS; s++) begin
      setEn(s);
      clrMsk(0, s);
      if (s > LP || s % 3 == 0) clrMsk(1, s);
      setRoute(s, (s % 2 == 0) ? 2 : 1, (s % 5 == 0) ? 3 : 0);
    end
    for (int k = 0; k < 16; k++) begin
      srcLines = NS'((64'h9A5C_3E71_0F2B_6D48 >> (k * 3)) ^ (64'h1 << (k + 20)));
      checkAll("R8");
      // R9: dropping the lowest eligible line moves the report on
      if (expAck(0) != 1023) srcLines[expAck(0)] = 1'b0;
      checkAll("R9");
    end
    // R9: withdrawing enables removes everything pending
    srcLines = '1;
    checkAll("R8");
    for (int s = 0; s < NS; s++) clrEn(s);
    checkAll("R9");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule